// File: doc/BRIEF.md
# Debounced Matrix Keypad Scanner

This block reads a sixteen-key matrix keypad through eight pins: four column drive outputs and four row sense inputs. A column counter walks the drive lines so that one column is pulled active at a time. Each sense line is active-low with a pull-up. A keypress in the selected column therefore pulls its row line low. Every sense line passes through a two-flop synchronizer and then through its own sample-count filter. The filter accepts a new level only after sixteen identical samples in a row.

A prescaler divides the system clock down to a sample tick, and the filters count only on that tick. The column counter dwells for a fixed number of sample ticks on each column and then steps to the next. Once any row has been accepted as pressed, the counter stops. The pressed key's column then stays driven until every row has been accepted as released. On the first accepted press, the block gives a one-cycle strobe and a four-bit key code. The code is the column index followed by the index of the lowest pressed row.

Top module: `keymat_scanner`

## Requirements
- R1: Exactly one column drive line is active at any time. With the default active-low polarity, column index c being selected means col_drive_o[c] is 0 and the other bits are 1.
- R2: While no row is accepted as pressed, the column index advances by one after every SCAN_DWELL sample ticks. It wraps from 3 to 0, so that after reset col_drive_o steps 1110, 1101, 1011, 0111, 1110.
- R3: While any row is accepted as pressed, the column index and col_drive_o do not change. Scanning resumes once all rows are accepted as released.
- R4: A row's accepted level changes only after DEB_COUNT (16) consecutive sample ticks on which its synchronized sample differs from the accepted level. A shorter run, as from contact bounce, is ignored, and the counting restarts.
- R5: A row sense line reads as pressed when low (row_sense_n_i[r] = 0) and as released when high. It reaches the filter through two synchronizing flops.
- R6: key_code_o = {column index[1:0], row index[1:0]}. A key at column c and row r gives code 4*c + r. When several rows are pressed, the lowest-numbered row is encoded.
- R7: key_valid_o is high for exactly one clock when an accepted press first appears. No further pulse occurs until every row has been accepted as released. key_code_o holds its value between pulses.
- R8: A synchronous active-high reset sets the column index to 0 (col_drive_o = 1110), clears every filter count, releases every row, and sets key_valid_o and key_code_o to 0.
- R9: The sample tick occurs once every TICK_DIV clocks. With TICK_DIV = 4 and SCAN_DWELL = 20, an idle column therefore stays selected for 80 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| row_sense_n_i | input | ROWS (4) | Row sense lines, active low, pulled up |
| col_drive_o | output | COLS (4) | Column drive lines, one active at a time |
| key_valid_o | output | 1 | One-cycle strobe for a newly accepted press |
| key_code_o | output | 4 | Column and row index of the pressed key |

## Verification
The delicate coincidence is a row filter accepting a press on the same sample tick on which the dwell ends and the column would step. If the step went ahead, the code would name the wrong column and the hold would sit on a column where the key cannot be seen. The bench provokes this by pressing keys at many phases of the dwell, including keys that become visible late in a column's window. A behavioural cycle model predicts column, strobe and code on every clock. The bench also checks directly that, for each press, the column is frozen where the key sits and the captured code matches it.

// File: rtl/keymat_pkg.sv
`timescale 1ns/1ps
package keymat_pkg;

   typedef enum logic {
      DRV_HIGH = 1'b0,
      DRV_LOW  = 1'b1
   } drive_pol_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/keymat_tick_gen.sv
`timescale 1ns/1ps
module keymat_tick_gen #(
   parameter int unsigned DIV = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("keymat_tick_gen: DIV must be at least 2");
      end
   endgenerate

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/keymat_row_filter.sv
`timescale 1ns/1ps
module keymat_row_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_COUNT   = 16
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tick_i,
   input  logic sense_n_i,
   output logic level_o,
   output logic press_accept_o
);
   localparam int unsigned CNT_W = (DEB_COUNT > 2) ? $clog2(DEB_COUNT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_COUNT - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       run_q;
   logic                   level_q;
   logic                   sample;
   logic                   differ;
   logic                   run_done;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("keymat_row_filter: SYNC_STAGES must be at least 2");
      end
      if (DEB_COUNT < 2) begin : g_bad_deb
         $error("keymat_row_filter: DEB_COUNT must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) sync_q[0] <= 1'b1;
               else       sync_q[0] <= sense_n_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) sync_q[s] <= 1'b1;
               else       sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign sample   = ~sync_q[SYNC_STAGES-1];
   assign differ   = sample ^ level_q;
   assign run_done = (run_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         level_q <= 1'b0;
         run_q   <= '0;
      end else if (tick_i) begin
         if (!differ) begin
            run_q <= '0;
         end else if (run_done) begin
            level_q <= sample;
            run_q   <= '0;
         end else begin
            run_q <= run_q + CNT_W'(1);
         end
      end
   end

   assign level_o        = level_q;
   assign press_accept_o = tick_i & differ & run_done & sample;
endmodule

// File: rtl/keymat_scan_ctr.sv
`timescale 1ns/1ps
module keymat_scan_ctr
   import keymat_pkg::*;
#(
   parameter int unsigned COLS      = 4,
   parameter int unsigned DWELL     = 24,
   parameter drive_pol_e  DRIVE_POL = DRV_LOW,
   localparam int unsigned COL_W    = $clog2(COLS)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             freeze_i,
   output logic [COL_W-1:0] scan_idx_o,
   output logic [COLS-1:0]  col_drv_o
);
   localparam int unsigned DW_W = (DWELL > 2) ? $clog2(DWELL) : 1;
   localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

   logic [DW_W-1:0]  dwell_q, dwell_d;
   logic [COL_W-1:0] scan_q, scan_d;
   logic [COLS-1:0]  onehot_q, onehot_d;

   always_comb begin
      dwell_d = dwell_q;
      scan_d  = scan_q;
      if (tick_i) begin
         if (freeze_i) begin
            dwell_d = '0;
         end else if (dwell_q == DW_LAST) begin
            dwell_d = '0;
            scan_d  = scan_q + COL_W'(1);
         end else begin
            dwell_d = dwell_q + DW_W'(1);
         end
      end
      onehot_d         = '0;
      onehot_d[scan_d] = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dwell_q  <= '0;
         scan_q   <= '0;
         onehot_q <= COLS'(1);
      end else begin
         dwell_q  <= dwell_d;
         scan_q   <= scan_d;
         onehot_q <= onehot_d;
      end
   end

   generate
      if (DRIVE_POL == DRV_LOW) begin : g_drive_low
         assign col_drv_o = ~onehot_q;
      end else begin : g_drive_high
         assign col_drv_o = onehot_q;
      end
   endgenerate

   assign scan_idx_o = scan_q;
endmodule

// File: rtl/keymat_key_encoder.sv
`timescale 1ns/1ps
module keymat_key_encoder #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned COL_W  = 2,
   localparam int unsigned ROW_W = $clog2(ROWS),
   localparam int unsigned CODE_W = COL_W + ROW_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ROWS-1:0]   row_level_i,
   input  logic [COL_W-1:0]  scan_idx_i,
   output logic              key_valid_o,
   output logic [CODE_W-1:0] key_code_o
);
   logic [ROW_W-1:0]  row_idx;
   logic              any_row;
   logic              held_q;
   logic              valid_q;
   logic [CODE_W-1:0] code_q;

   always_comb begin
      row_idx = '0;
      for (int r = ROWS - 1; r >= 0; r--) begin
         if (row_level_i[r]) row_idx = ROW_W'(r);
      end
   end

   assign any_row = |row_level_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         held_q  <= 1'b0;
         valid_q <= 1'b0;
         code_q  <= '0;
      end else begin
         held_q  <= any_row;
         valid_q <= any_row & ~held_q;
         if (any_row && !held_q) code_q <= {scan_idx_i, row_idx};
      end
   end

   assign key_valid_o = valid_q;
   assign key_code_o  = code_q;
endmodule

// File: rtl/keymat_scanner.sv
`timescale 1ns/1ps
module keymat_scanner
   import keymat_pkg::*;
#(
   parameter int unsigned COLS        = 4,
   parameter int unsigned ROWS        = 4,
   parameter int unsigned TICK_DIV    = 50000,
   parameter int unsigned DEB_COUNT   = 16,
   parameter int unsigned SCAN_DWELL  = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter drive_pol_e  DRIVE_POL   = DRV_LOW,
   localparam int unsigned COL_W      = $clog2(COLS),
   localparam int unsigned ROW_W      = $clog2(ROWS),
   localparam int unsigned CODE_W     = COL_W + ROW_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ROWS-1:0]   row_sense_n_i,
   output logic [COLS-1:0]   col_drive_o,
   output logic              key_valid_o,
   output logic [CODE_W-1:0] key_code_o
);
   logic              sample_tick;
   logic [ROWS-1:0]   row_level;
   logic [ROWS-1:0]   row_accept;
   logic [COL_W-1:0]  scan_idx;
   logic              freeze;

   generate
      if (!is_pow2(COLS) || COLS < 2) begin : g_bad_cols
         $error("keymat_scanner: COLS must be a power of two, at least 2");
      end
      if (!is_pow2(ROWS) || ROWS < 2) begin : g_bad_rows
         $error("keymat_scanner: ROWS must be a power of two, at least 2");
      end
      if (TICK_DIV < SYNC_STAGES + 1) begin : g_bad_tick
         $error("keymat_scanner: TICK_DIV must exceed the synchronizer depth");
      end
      if (SCAN_DWELL <= DEB_COUNT) begin : g_bad_dwell
         $error("keymat_scanner: SCAN_DWELL must exceed DEB_COUNT");
      end
   endgenerate

   keymat_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_o (sample_tick)
   );

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         keymat_row_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .DEB_COUNT   (DEB_COUNT)
         ) u_filter (
            .clk_i          (clk_i),
            .rst_i          (rst_i),
            .tick_i         (sample_tick),
            .sense_n_i      (row_sense_n_i[r]),
            .level_o        (row_level[r]),
            .press_accept_o (row_accept[r])
         );
      end
   endgenerate

   // Freeze on the tick that accepts a press, so the column cannot step away
   assign freeze = (|row_level) | (|row_accept);

   keymat_scan_ctr #(
      .COLS      (COLS),
      .DWELL     (SCAN_DWELL),
      .DRIVE_POL (DRIVE_POL)
   ) u_scan (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .tick_i     (sample_tick),
      .freeze_i   (freeze),
      .scan_idx_o (scan_idx),
      .col_drv_o  (col_drive_o)
   );

   keymat_key_encoder #(
      .ROWS  (ROWS),
      .COL_W (COL_W)
   ) u_enc (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .row_level_i (row_level),
      .scan_idx_i  (scan_idx),
      .key_valid_o (key_valid_o),
      .key_code_o  (key_code_o)
   );
endmodule

// File: rtl/keymat_scanner_chk.sv
`timescale 1ns/1ps
module keymat_scanner_chk
   import keymat_pkg::*;
#(
   parameter int unsigned COLS      = 4,
   parameter int unsigned ROWS      = 4,
   parameter drive_pol_e  DRIVE_POL = DRV_LOW,
   localparam int unsigned COL_W    = $clog2(COLS),
   localparam int unsigned ROW_W    = $clog2(ROWS)
) (
   input logic                     clk_i,
   input logic                     rst_i,
   input logic [COLS-1:0]          col_drv_i,
   input logic                     key_valid_i,
   input logic [COL_W+ROW_W-1:0]   key_code_i,
   input logic                     sample_tick_i,
   input logic [ROWS-1:0]          row_level_i,
   input logic [COL_W-1:0]         scan_idx_i
);
   logic [COLS-1:0] active_cols;
   assign active_cols = (DRIVE_POL == DRV_LOW) ? ~col_drv_i : col_drv_i;

   assert_one_column_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(active_cols) == 1 && active_cols[scan_idx_i]);

   assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(scan_idx_i) |-> ($past(sample_tick_i) && scan_idx_i == $past(scan_idx_i) + COL_W'(1)));

   assert_hold_while_pressed_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (|row_level_i) |=> $stable(scan_idx_i));

   assert_level_on_tick_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(row_level_i) |-> $past(sample_tick_i));

   assert_code_column_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      key_valid_i |-> (key_code_i[ROW_W +: COL_W] == scan_idx_i));

   assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      key_valid_i |=> !key_valid_i);

   assert_reset_state_R8: assert property (@(posedge clk_i)
      rst_i |=> (!key_valid_i && scan_idx_i == '0 && row_level_i == '0));
endmodule

bind keymat_scanner keymat_scanner_chk #(
   .COLS      (COLS),
   .ROWS      (ROWS),
   .DRIVE_POL (DRIVE_POL)
) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .col_drv_i     (col_drive_o),
   .key_valid_i   (key_valid_o),
   .key_code_i    (key_code_o),
   .sample_tick_i (sample_tick),
   .row_level_i   (row_level),
   .scan_idx_i    (scan_idx)
);

// File: tb/keymat_scanner_bench.sv
`timescale 1ns/1ps
module keymat_scanner_bench;
   localparam int DIV   = 4;
   localparam int DEB   = 16;
   localparam int DWELL = 20;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] row_n;
   logic [3:0] col;
   logic       valid;
   logic [3:0] code;
   logic [15:0] keys = '0;   // index 4*column + row

   int checks = 0;
   int fails  = 0;
   int cycle  = 0;
   int pulses = 0;
   int last_code = -1;
   int col_changes = 0;
   int chg_prev = 0;
   int chg_last = 0;
   logic [3:0] col_prev = 4'b1110;

   always #2.5 clk = ~clk;

   keymat_scanner #(
      .TICK_DIV   (DIV),
      .DEB_COUNT  (DEB),
      .SCAN_DWELL (DWELL)
   ) u_keymat_scanner (
      .clk_i         (clk),
      .rst_i         (rst),
      .row_sense_n_i (row_n),
      .col_drive_o   (col),
      .key_valid_o   (valid),
      .key_code_o    (code)
   );

   // keypad: a closed key joins its column line to its row line
   always_comb begin
      row_n = 4'b1111;
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            if (keys[c*4 + r] && !col[c]) row_n[r] = 1'b0;
   end

   // behavioural reference model
   int   m_t, m_dwell, m_scan, m_code;
   int   m_cnt[4];
   logic [3:0] m_s0, m_s1, m_lvl;
   bit   m_held, m_valid;

   always @(posedge clk) begin : model
      logic [3:0] raw, smp, lvl_n;
      bit tick, acc;
      int low;
      if (rst) begin
         m_t = 0; m_dwell = 0; m_scan = 0; m_code = 0;
         m_s0 = '1; m_s1 = '1; m_lvl = '0;
         m_held = 0; m_valid = 0;
         for (int r = 0; r < 4; r++) m_cnt[r] = 0;
      end else begin
         for (int r = 0; r < 4; r++) raw[r] = !keys[m_scan*4 + r];
         tick = (m_t == DIV - 1);
         m_t  = tick ? 0 : m_t + 1;
         smp  = ~m_s1;
         m_s1 = m_s0;
         m_s0 = raw;
         lvl_n = m_lvl;
         acc = 0;
         if (tick) begin
            for (int r = 0; r < 4; r++) begin
               if (smp[r] == m_lvl[r]) m_cnt[r] = 0;
               else if (m_cnt[r] == DEB - 1) begin
                  lvl_n[r] = smp[r];
                  m_cnt[r] = 0;
                  if (smp[r]) acc = 1;
               end else m_cnt[r] = m_cnt[r] + 1;
            end
            if ((|m_lvl) || acc) m_dwell = 0;
            else if (m_dwell == DWELL - 1) begin
               m_dwell = 0;
               m_scan = (m_scan + 1) % 4;
            end else m_dwell = m_dwell + 1;
         end
         low = 0;
         for (int r = 3; r >= 0; r--) if (m_lvl[r]) low = r;
         m_valid = (|m_lvl) && !m_held;
         if (m_valid) m_code = m_scan*4 + low;
         m_held = |m_lvl;
         m_lvl = lvl_n;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycle);
      end
   endtask

   // per-cycle comparison and observation, away from the active edge
   always @(negedge clk) begin
      cycle++;
      if (!rst) begin
         logic [3:0] exp_col;
         exp_col = ~(4'b0001 << m_scan);
         chk(col == exp_col, "R1 column drive", col, exp_col);
         chk(valid == m_valid, "R7 key_valid", valid, m_valid);
         chk(code == 4'(m_code), "R6 key_code", code, m_code);
         if (valid) begin
            pulses++;
            last_code = code;
         end
         if (col != col_prev) begin
            col_changes++;
            chg_prev = chg_last;
            chg_last = cycle;
         end
         col_prev = col;
      end
   end

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_pulse(input int limit);
      int start;
      start = pulses;
      for (int i = 0; i < limit && pulses == start; i++) @(negedge clk);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual cycles %0d expected below 150000", cycle);
      report();
   end

   initial begin : stimulus
      int p0, c0;
      rst = 1'b1;
      wait_cycles(5);
      rst = 1'b0;
      @(negedge clk);
      chk(col == 4'b1110, "R8 reset column", col, 4'b1110);
      chk(valid == 1'b0, "R8 reset valid", valid, 0);
      chk(code == 4'd0, "R8 reset code", code, 0);

      // idle scanning: dwell spacing and step order
      wait_cycles(400);
      chk(col_changes >= 4, "R2 idle column steps", col_changes, 4);
      chk(chg_last - chg_prev == DIV*DWELL, "R9 dwell length in clocks",
          chg_last - chg_prev, DIV*DWELL);
      chk(pulses == 0, "R5 released lines read as idle", pulses, 0);

      // single key, column 2 row 1
      keys[9] = 1'b1;
      wait_pulse(1000);
      chk(pulses == 1, "R5 low sense line reads as press", pulses, 1);
      chk(last_code == 9, "R6 code column 2 row 1", last_code, 9);
      c0 = col_changes;
      wait_cycles(400);
      chk(col == 4'b1011, "R3 column held on pressed key", col, 4'b1011);
      chk(col_changes == c0, "R3 no steps while held", col_changes, c0);
      chk(pulses == 1, "R7 no repeat while held", pulses, 1);
      keys[9] = 1'b0;
      wait_cycles(400);
      chk(col_changes > c0, "R3 scanning resumes after release", col_changes - c0, 1);

      // bouncing contact on column 0 row 2: runs too short to be accepted
      p0 = pulses;
      for (int i = 0; i < 40; i++) begin
         keys[2] = 1'b1;
         wait_cycles(7*DIV);
         keys[2] = 1'b0;
         wait_cycles(3*DIV);
      end
      chk(pulses == p0, "R4 bounce ignored", pulses - p0, 0);
      keys[2] = 1'b1;
      wait_pulse(1000);
      chk(last_code == 2, "R4 steady press accepted", last_code, 2);
      keys[2] = 1'b0;
      wait_cycles(300);

      // two rows in column 1: lowest row wins, later key adds no pulse
      keys[7] = 1'b1;
      keys[5] = 1'b1;
      wait_pulse(1000);
      chk(last_code == 5, "R6 lowest row wins", last_code, 5);
      p0 = pulses;
      keys[4] = 1'b1;
      wait_cycles(300);
      chk(pulses == p0, "R7 extra key while held", pulses - p0, 0);
      keys[7] = 1'b0;
      keys[5] = 1'b0;
      keys[4] = 1'b0;
      wait_cycles(300);

      // top corner key, column 3 row 3
      keys[15] = 1'b1;
      wait_pulse(1000);
      chk(last_code == 15, "R6 code column 3 row 3", last_code, 15);
      keys[15] = 1'b0;
      wait_cycles(300);

      // reset in the middle of a held press
      keys[6] = 1'b1;
      wait_pulse(1000);
      rst = 1'b1;
      wait_cycles(3);
      keys[6] = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk(col == 4'b1110, "R8 reset while held", col, 4'b1110);
      chk(code == 4'd0, "R8 code cleared", code, 0);
      wait_cycles(200);
      report();
   end
endmodule